// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Sequencer

This block runs one external memory access on a bus where the address and data share the same pins. It advances on a phase tick, `tcl_tick`, which pulses once per TCL. A TCL is half a CPU clock period. A request carries a direction, an address and write data. The sequencer then steps through four phases:

- address strobe (`ale`),
- an optional settling gap,
- the read or write strobe (`rd_n` / `wr_n`),
- a float phase in which nothing drives the pins.

It drives separate enables for the address and for the write data onto the shared pins. It captures read data when the read strobe rises, and pulses `done` on the last TCL of the access.

Four timing controls shape the cycle, and all of them are sampled when a request is accepted:

- `cfg_ta` lengthens the address strobe and the gap after it.
- `cfg_tc` adds memory wait states to the strobe.
- `cfg_tf` extends the float phase.
- `cfg_rwd` moves the strobe one TCL later and shortens it by one TCL.

A whole access takes 6 + 2·ta + tc + tf TCLs in either strobe placement.

The request side is a valid/ready port. `req_ready` is high only while the sequencer is idle and `tcl_tick` is high. A request transfers on a clock where `req_valid` and `req_ready` are both high. A requester may hold `req_valid` for as long as it likes; nothing is lost while `req_ready` is low. The result side has no back-pressure: `rdata` is valid in the clock where `done` is high and holds until the next read captures.

Top module: `mux_bus_seq`

## Requirements
- R1: `req_ready` is 1 only when the sequencer is idle and `tcl_tick` is 1. A request held valid during an access is not taken until the access has ended.
- R2: TCLs are counted from the first address-strobe TCL up to and including the TCL in which `done` pulses. An access lasts 6 + 2·ta + tc + tf of them.
- R3: `ale` is 1 for exactly 1 + ta TCLs at the start of the access. During those TCLs `addr_oe` is 1 and `ad_out` carries the request address.
- R4: Strobe placement depends on `cfg_rwd`. With `cfg_rwd`=1 the strobe (`rd_n` for a read, `wr_n` for a write) goes low 1 + ta TCLs after `ale` falls. With `cfg_rwd`=0 it goes low ta TCLs after `ale` falls.
- R5: The strobe stays low for 2 + tc TCLs when `cfg_rwd`=1 and for 3 + tc TCLs when `cfg_rwd`=0. The other strobe stays high for the whole access.
- R6: The address stays driven (`addr_oe`=1, `ad_out` = address) from the first TCL of the access until the strobe goes low. With `cfg_rwd`=0 it is also driven during the first strobe TCL.
- R7: On a write, `wdata_oe` is 1 and `ad_out` carries the write data on every strobe TCL in which the address is not driven. On a read, `wdata_oe` stays 0 for the whole access.
- R8: After the strobe rises, the access spends 2 + tf TCLs with both strobes high, `ale` low and both output enables 0.
- R9: A read captures `ad_in` in the final strobe TCL, which is the rising edge of `rd_n`, and presents it on `rdata` in the `done` clock. A write leaves `rdata` unchanged.
- R10: `done` is high for exactly one clock, the tick clock of the final TCL.
- R11: The values of `cfg_ta` (1 bit), `cfg_tc` (4 bits), `cfg_tf` (1 bit) and `cfg_rwd` (1 = delayed strobe) are taken when the request is accepted. Changing them during an access has no effect on that access.
- R12: While reset is active and after it is released, `ale`=0, `rd_n`=`wr_n`=1, both output enables are 0 and `done`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tcl_tick | input | 1 | One-clock pulse per TCL |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be accepted this clock |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | DW | Access address |
| req_wdata | input | DW | Write data |
| cfg_ta | input | 1 | Address strobe stretch, 0 or 1 TCL |
| cfg_tc | input | TC_W | Strobe wait states in TCLs |
| cfg_tf | input | 1 | Float stretch, 0 or 1 TCL |
| cfg_rwd | input | 1 | 1 = delayed strobe placement |
| ale | output | 1 | Address latch strobe, active high |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| addr_oe | output | 1 | Drive address on the shared pins |
| wdata_oe | output | 1 | Drive write data on the shared pins |
| ad_out | output | DW | Value for the shared pins |
| ad_in | input | DW | Value read from the shared pins |
| rdata | output | DW | Captured read data |
| done | output | 1 | End-of-access pulse |

## Verification
The hardest cases to reach from the ports depend on the stored settings, not on the live inputs:

- the no-gap placement with ta=0, where the address must be held into the first strobe TCL;
- the capture instant of the read data;
- the stored settings outliving a change on the inputs.

The bench's memory model returns a different word on each read-strobe TCL, so any early or late capture shows up as a wrong value. One access rewrites every `cfg_*` input in the clock after it is accepted, and another holds `req_valid` high for the whole access. Tick spacing is three clocks, so stretching the strobes by clocks rather than TCLs would be detected.

// File: rtl/mbs_pkg.sv
package mbs_pkg;
  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_ALE  = 3'd1,
    PH_GAP  = 3'd2,
    PH_STRB = 3'd3,
    PH_FLT  = 3'd4
  } phase_e;
endpackage

// File: rtl/mbs_phase_ctl.sv
module mbs_phase_ctl
  import mbs_pkg::*;
#(
  parameter int TC_W  = 4,
  parameter int CNT_W = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            start,
  input  logic            cfg_ta,
  input  logic [TC_W-1:0] cfg_tc,
  input  logic            cfg_tf,
  input  logic            cfg_rwd,
  output phase_e          phase,
  output logic            addr_hold,
  output logic            strb_last,
  output logic            fin
);
  logic [CNT_W-1:0] cnt, cnt_nx;
  phase_e           phase_nx;
  logic             ta_q, tf_q, rwd_q, first_q, first_nx;
  logic [TC_W-1:0]  tc_q;
  logic [CNT_W-1:0] gap_len, strb_len, flt_len;

  always_comb begin
    gap_len  = rwd_q ? CNT_W'(ta_q) + CNT_W'(1) : CNT_W'(ta_q);
    strb_len = CNT_W'(tc_q) + (rwd_q ? CNT_W'(2) : CNT_W'(3));
    flt_len  = CNT_W'(tf_q) + CNT_W'(2);
  end

  always_comb begin
    phase_nx = phase;
    cnt_nx   = cnt;
    first_nx = first_q;
    if (start) begin
      phase_nx = PH_ALE;
      cnt_nx   = CNT_W'(cfg_ta);
      first_nx = 1'b0;
    end else if (tick && phase != PH_IDLE) begin
      first_nx = 1'b0;
      if (cnt != '0) begin
        cnt_nx = cnt - CNT_W'(1);
      end else begin
        unique case (phase)
          PH_ALE: begin
            if (gap_len == '0) begin
              phase_nx = PH_STRB;
              cnt_nx   = strb_len - CNT_W'(1);
              first_nx = 1'b1;
            end else begin
              phase_nx = PH_GAP;
              cnt_nx   = gap_len - CNT_W'(1);
            end
          end
          PH_GAP: begin
            phase_nx = PH_STRB;
            cnt_nx   = strb_len - CNT_W'(1);
            first_nx = 1'b1;
          end
          PH_STRB: begin
            phase_nx = PH_FLT;
            cnt_nx   = flt_len - CNT_W'(1);
          end
          default: begin
            phase_nx = PH_IDLE;
            cnt_nx   = '0;
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      cnt     <= '0;
      first_q <= 1'b0;
      ta_q    <= 1'b0;
      tc_q    <= '0;
      tf_q    <= 1'b0;
      rwd_q   <= 1'b0;
    end else begin
      phase   <= phase_nx;
      cnt     <= cnt_nx;
      first_q <= first_nx;
      if (start) begin
        ta_q  <= cfg_ta;
        tc_q  <= cfg_tc;
        tf_q  <= cfg_tf;
        rwd_q <= cfg_rwd;
      end
    end
  end

  assign addr_hold = first_q && !rwd_q;
  assign strb_last = (phase == PH_STRB) && (cnt == '0);
  assign fin       = (phase == PH_FLT) && (cnt == '0) && tick;
endmodule

// File: rtl/mbs_pin_drv.sv
module mbs_pin_drv
  import mbs_pkg::*;
#(
  parameter int DW = 16
) (
  input  phase_e          phase,
  input  logic            addr_hold,
  input  logic            is_wr,
  input  logic [DW-1:0]   addr_q,
  input  logic [DW-1:0]   wdata_q,
  output logic            ale,
  output logic            rd_n,
  output logic            wr_n,
  output logic            addr_oe,
  output logic            wdata_oe,
  output logic [DW-1:0]   ad_out
);
  logic strobe;

  always_comb begin
    strobe   = (phase == PH_STRB);
    ale      = (phase == PH_ALE);
    rd_n     = !(strobe && !is_wr);
    wr_n     = !(strobe && is_wr);
    addr_oe  = (phase == PH_ALE) || (phase == PH_GAP) || (strobe && addr_hold);
    wdata_oe = strobe && is_wr && !addr_hold;
    ad_out   = wdata_oe ? wdata_q : addr_q;
  end
endmodule

// File: rtl/mbs_rd_capture.sv
module mbs_rd_capture #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          strb_last,
  input  logic          is_wr,
  input  logic [DW-1:0] ad_in,
  output logic [DW-1:0] rdata
);
  always_ff @(posedge clk) begin
    if (!rst_n)
      rdata <= '0;
    else if (tick && strb_last && !is_wr)
      rdata <= ad_in;
  end
endmodule

// File: rtl/mux_bus_seq.sv
module mux_bus_seq
  import mbs_pkg::*;
#(
  parameter int DW    = 16,
  parameter int TC_W  = 4,
  localparam int CNT_W = $clog2((1 << TC_W) + 3) + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tcl_tick,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic            req_write,
  input  logic [DW-1:0]   req_addr,
  input  logic [DW-1:0]   req_wdata,
  input  logic            cfg_ta,
  input  logic [TC_W-1:0] cfg_tc,
  input  logic            cfg_tf,
  input  logic            cfg_rwd,
  output logic            ale,
  output logic            rd_n,
  output logic            wr_n,
  output logic            addr_oe,
  output logic            wdata_oe,
  output logic [DW-1:0]   ad_out,
  input  logic [DW-1:0]   ad_in,
  output logic [DW-1:0]   rdata,
  output logic            done
);
  phase_e        phase;
  logic          accept, addr_hold, strb_last, is_wr;
  logic [DW-1:0] addr_q, wdata_q;

  assign req_ready = (phase == PH_IDLE) && tcl_tick;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      is_wr   <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      is_wr   <= req_write;
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  mbs_phase_ctl #(.TC_W(TC_W), .CNT_W(CNT_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .tick(tcl_tick), .start(accept),
    .cfg_ta(cfg_ta), .cfg_tc(cfg_tc), .cfg_tf(cfg_tf), .cfg_rwd(cfg_rwd),
    .phase(phase), .addr_hold(addr_hold), .strb_last(strb_last), .fin(done)
  );

  mbs_pin_drv #(.DW(DW)) u_drv (
    .phase(phase), .addr_hold(addr_hold), .is_wr(is_wr),
    .addr_q(addr_q), .wdata_q(wdata_q),
    .ale(ale), .rd_n(rd_n), .wr_n(wr_n),
    .addr_oe(addr_oe), .wdata_oe(wdata_oe), .ad_out(ad_out)
  );

  mbs_rd_capture #(.DW(DW)) u_cap (
    .clk(clk), .rst_n(rst_n), .tick(tcl_tick), .strb_last(strb_last),
    .is_wr(is_wr), .ad_in(ad_in), .rdata(rdata)
  );
endmodule

// File: rtl/mux_bus_seq_chk.sv
module mux_bus_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic tcl_tick,
  input logic req_ready,
  input logic ale,
  input logic rd_n,
  input logic wr_n,
  input logic addr_oe,
  input logic wdata_oe,
  input logic done
);
  // R1
  ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (tcl_tick && !ale && rd_n && wr_n && !addr_oe));
  // R2
  tick_paced_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(tcl_tick) |-> $stable({ale, rd_n, wr_n, addr_oe, wdata_oe}));
  // R3
  ale_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> addr_oe);
  // R6
  addr_across_ale_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ale) |-> addr_oe);
  // R5
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n));
  // R7
  no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(addr_oe && wdata_oe));
  // R7
  wdata_in_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wdata_oe |-> !wr_n);
  // R8
  done_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (rd_n && wr_n && !ale && !addr_oe && !wdata_oe));
  // R10
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind mux_bus_seq mux_bus_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tcl_tick(tcl_tick), .req_ready(req_ready),
  .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .addr_oe(addr_oe),
  .wdata_oe(wdata_oe), .done(done)
);

// File: tb/mux_bus_seq_bench.sv
module mux_bus_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  div = 2'd0;
  logic        tcl_tick;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [15:0] req_addr = '0, req_wdata = '0;
  logic        cfg_ta = 1'b0, cfg_tf = 1'b0, cfg_rwd = 1'b0;
  logic [3:0]  cfg_tc = '0;
  logic        req_ready, ale, rd_n, wr_n, addr_oe, wdata_oe, done;
  logic [15:0] ad_out, ad_in, rdata, mem_word = '0;
  logic [4:0]  rd_ticks = '0;
  int          total = 0, bad = 0;
  logic [15:0] last_rdata = '0;

  always #2.5 clk = ~clk;
  always @(negedge clk) div <= (div == 2'd2) ? 2'd0 : div + 2'd1;
  assign tcl_tick = (div == 2'd2);

  always @(posedge clk)
    if (rd_n) rd_ticks <= '0;
    else if (tcl_tick) rd_ticks <= rd_ticks + 5'd1;
  assign ad_in = !rd_n ? (mem_word ^ {11'd0, rd_ticks}) : 16'hF0F0;

  mux_bus_seq u_mux_bus_seq (
    .clk(clk), .rst_n(rst_n), .tcl_tick(tcl_tick), .req_valid(req_valid),
    .req_ready(req_ready), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .cfg_ta(cfg_ta), .cfg_tc(cfg_tc), .cfg_tf(cfg_tf),
    .cfg_rwd(cfg_rwd), .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .addr_oe(addr_oe),
    .wdata_oe(wdata_oe), .ad_out(ad_out), .ad_in(ad_in), .rdata(rdata),
    .done(done)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic sample();
    @(negedge clk);
    #1;
  endtask

  // R12
  task automatic test_reset();
    repeat (4) sample();
    check(ale == 0 && rd_n && wr_n && !addr_oe && !wdata_oe && !done, "R12 in reset",
          {ale, rd_n, wr_n, addr_oe, wdata_oe, done}, 6'b011000);
    rst_n = 1'b1;
    repeat (3) sample();
    check(ale == 0 && rd_n && wr_n && !addr_oe && !done, "R12 after release",
          {ale, rd_n, wr_n, addr_oe, done}, 5'b01100);
    check(req_ready == tcl_tick, "R1 idle ready", req_ready, tcl_tick);
  endtask

  task automatic run_txn(input bit wr, input logic [15:0] a, input logic [15:0] wd,
                         input bit ta, input logic [3:0] tc, input bit tf, input bit rwd,
                         input bit scramble, input bit hold_valid);
    bit e_ale = 0, e_addr = 0, e_wd = 0, e_flt = 0, e_rdy = 0, e_done = 0;
    int first_low = -1, low_cnt = 0, k = 0;
    int n_ale = 1 + ta;
    int gap = rwd ? 1 + ta : ta;
    int strb = (rwd ? 2 : 3) + tc;
    int s0 = n_ale + gap;
    int n_tot = s0 + strb + 2 + tf;
    logic [15:0] exp_rd;
    req_write = wr; req_addr = a; req_wdata = wd;
    cfg_ta = ta; cfg_tc = tc; cfg_tf = tf; cfg_rwd = rwd;
    mem_word = a ^ 16'h5A5A;
    req_valid = 1'b1;
    do sample(); while (!(tcl_tick && req_ready));
    @(posedge clk);
    #1;
    if (!hold_valid) req_valid = 1'b0;
    if (scramble) begin
      cfg_ta = ~ta; cfg_tc = ~tc; cfg_tf = ~tf; cfg_rwd = ~rwd;
      req_addr = ~a; req_wdata = ~wd; req_write = ~wr;
    end
    while (k < 64) begin
      sample();
      if (tcl_tick) begin
        bit strobe_exp = (k >= s0) && (k < s0 + strb);
        bit aoe_exp = k < s0 + (rwd ? 0 : 1);
        bit strobe_act = wr ? !wr_n : !rd_n;
        if (ale != (k < n_ale)) e_ale = 1;
        if (addr_oe != aoe_exp || (addr_oe && ad_out != a)) e_addr = 1;
        if (wdata_oe != (wr && strobe_exp && !aoe_exp) || (wdata_oe && ad_out != wd)) e_wd = 1;
        if ((wr ? !rd_n : !wr_n)) e_wd = 1;
        if (strobe_act) begin
          if (first_low < 0) first_low = k;
          low_cnt++;
        end
        if (k >= s0 + strb && (!rd_n || !wr_n || ale || addr_oe || wdata_oe)) e_flt = 1;
        if (req_ready) e_rdy = 1;
        if (done != (k == n_tot - 1)) e_done = 1;
        if (done) break;
        k++;
      end else if (done) e_done = 1;
    end
    req_valid = 1'b0;
    exp_rd = wr ? last_rdata : (mem_word ^ 16'(strb - 1));
    check(k + 1 == n_tot, "R2 cycle length", k + 1, n_tot);
    check(!e_ale, "R3 ale width", e_ale, 0);
    check(first_low == s0, "R4 strobe start", first_low, s0);
    check(low_cnt == strb, "R5 strobe length", low_cnt, strb);
    check(!e_addr, "R6 address drive", e_addr, 0);
    check(!e_wd, "R7 write data drive", e_wd, 0);
    check(!e_flt, "R8 float phase", e_flt, 0);
    check(!e_done, "R10 done pulse", e_done, 0);
    check(rdata == exp_rd, "R9 read data", rdata, exp_rd);
    if (hold_valid) check(!e_rdy, "R1 ready low while busy", e_rdy, 0);
    if (scramble) check(k + 1 == n_tot && !e_addr, "R11 config sampled", k + 1, n_tot);
    last_rdata = exp_rd;
    sample();
    check(!done, "R10 done cleared", done, 0);
  endtask

  task automatic test_base_read();    run_txn(0, 16'h1234, 16'h0,    0, 4'd0, 0, 1, 0, 0); endtask
  task automatic test_base_write();   run_txn(1, 16'h2468, 16'hBEEF, 0, 4'd0, 0, 0, 0, 0); endtask
  task automatic test_stretch_read(); run_txn(0, 16'hA001, 16'h0,    1, 4'd5, 1, 0, 0, 0); endtask
  task automatic test_max_write();    run_txn(1, 16'h0FF0, 16'hC3C3, 1, 4'd15, 1, 1, 0, 0); endtask
  task automatic test_scramble();     run_txn(0, 16'h7E57, 16'h0,    0, 4'd2, 0, 0, 1, 0); endtask
  task automatic test_hold_valid();   run_txn(1, 16'h5555, 16'h1111, 1, 4'd1, 0, 0, 0, 1); endtask
  task automatic test_after_write();  run_txn(0, 16'h8000, 16'h0,    0, 4'd0, 1, 0, 0, 0); endtask

  initial begin
    test_reset();
    test_base_read();
    test_base_write();
    test_stretch_read();
    test_max_write();
    test_scramble();
    test_hold_valid();
    test_after_write();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL R2 watchdog: actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule